// File: doc/BRIEF.md
# Microcoded Single-Accumulator Decimation Engine

This block converts a 1-bit oversampled delta-sigma bitstream into signed 16-bit PCM words, one word per 256 input bits. It does not use a chain of parallel integrators, combs and FIR multipliers. Instead it time-shares one 32-bit accumulator across the whole filter. A program ROM holds a fixed 256-step schedule. A step counter walks through that schedule and performs exactly one micro-operation per input bit, so the processing clock is the bit clock itself and no faster clock is needed.

Filter state that must survive between operations, or from one output frame to the next, sits in a small register-file RAM. Each control word carries three fields: an operation, a RAM address and a signed 16-bit immediate, which is used either as a constant or as a filter coefficient. On a multiply-accumulate step, the input bit only chooses the sign of the coefficient, so no multiplier is needed. The supplied program applies a triangular window over the frame and then adds the windowed sum of the previous frame, which gives a second-order response across two frames.

Top module: `dsm_microdecim`

## Requirements
- R1: `pcm_valid` is high for exactly one cycle in every 256. The first pulse follows the edge that executes step 252 of the first frame after reset, which is the 253rd rising edge with reset low. Each later pulse comes 256 cycles after the one before.
- R2: The step counter advances by one on every clock and wraps from 255 to 0, so the schedule repeats every 256 input bits.
- R3: On a multiply-accumulate step, an input bit of 1 adds the coefficient and a 0 subtracts it. On every other step the input bit has no effect.
- R4: On the output step, `pcm_out` takes the accumulator shifted right arithmetically by `OUT_SHIFT` (default 1). The result is clamped to the range 32767 down to -32768.
- R5: The output of frame f equals the windowed sum of frame f plus the windowed sum of frame f-1, both held through RAM. Frame f-1 counts as 0 in the first frame after reset.
- R6: A synchronous reset clears the step counter, the accumulator, the RAM, `pcm_out` and `pcm_valid`. A reset in the middle of a frame restarts the schedule at step 0.
- R7: `pcm_out` holds its value between `pcm_valid` pulses.
- R8: The operation codes are NOP=0, LDI=1 (load immediate), LDM=2 (load RAM), ADDM=3, SUBM=4, MAC=5 (add ±immediate), STM=6 (store accumulator) and OUT=7. The example program runs as follows:
  - Step 0: LDI 0.
  - Steps 1..249: MAC with coefficient 4*min(s, 250-s).
  - Step 250: STM to address 0.
  - Step 251: ADDM from address 1.
  - Step 252: OUT.
  - Step 253: LDM from address 0.
  - Step 254: STM to address 1.
  - Step 255: SUBM from address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one micro-operation per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Oversampled modulator bit (1 = +1, 0 = -1) |
| pcm_out | output | 16 | Signed decimated output word |
| pcm_valid | output | 1 | One-cycle strobe marking a new `pcm_out` |

## Verification
The bench drives two frames of all ones and then two frames of all zeros. The first frame of each pair stays just inside the range and the second pushes the sum past both saturation limits. A design that wraps instead of clamping would show a wrong sign there, and one that drops the previous-frame term would never reach saturation. Random frames exercise the coefficient signs and confirm that bits on the non-MAC steps are ignored. A reset in the middle of a frame checks that the RAM really clears, since a stale previous-frame sum would shift the next output. Strobe position and `pcm_out` hold are checked in every frame, so an off-by-one in the step counter or a glitching output register shows up at once.

// File: rtl/dsm_decim_pkg.sv
package dsm_decim_pkg;

    // Micro-operation encoding held in the program ROM (R8)
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LDI  = 3'd1,
        OP_LDM  = 3'd2,
        OP_ADDM = 3'd3,
        OP_SUBM = 3'd4,
        OP_MAC  = 3'd5,
        OP_STM  = 3'd6,
        OP_OUT  = 3'd7
    } op_e;

endpackage

// File: rtl/dsm_step_seq.sv
module dsm_step_seq #(
    parameter int STEPS = 256,
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SEQ_W-1:0] step
);

    localparam logic [SEQ_W-1:0] LAST = SEQ_W'(STEPS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= '0;
        end else if (step == LAST) begin
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

    // R2: schedule wraps after the last step
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (step == LAST) |=> (step == '0));

    // R2: one step per clock otherwise
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (step != LAST) |=> (step == $past(step) + 1'b1));

endmodule

// File: rtl/dsm_prog_rom.sv
module dsm_prog_rom
    import dsm_decim_pkg::*;
#(
    parameter int STEPS     = 256,
    parameter int SEQ_W     = 8,
    parameter int RAM_AW    = 2,
    parameter int COEF_W    = 16,
    parameter int COEF_GAIN = 4
) (
    input  logic [SEQ_W-1:0]  step,
    output op_e               op,
    output logic [RAM_AW-1:0] addr,
    output logic [COEF_W-1:0] imm
);

    // Tail of the frame: store, combine, emit, rotate history, clear
    localparam int MAC_LAST = STEPS - 7;
    localparam int RAMP_TOP = STEPS - 6;
    localparam int S_STORE  = STEPS - 6;
    localparam int S_COMB   = STEPS - 5;
    localparam int S_EMIT   = STEPS - 4;
    localparam int S_RELOAD = STEPS - 3;
    localparam int S_KEEP   = STEPS - 2;
    localparam int S_CLEAR  = STEPS - 1;

    localparam logic [RAM_AW-1:0] A_CUR  = RAM_AW'(0);
    localparam logic [RAM_AW-1:0] A_PREV = RAM_AW'(1);

    int s_i;
    int ramp_i;

    always_comb begin
        s_i    = int'(step);
        ramp_i = (s_i < RAMP_TOP - s_i) ? s_i : (RAMP_TOP - s_i);
        op     = OP_NOP;
        addr   = '0;
        imm    = '0;
        if (s_i == 0) begin
            op  = OP_LDI;
        end else if (s_i <= MAC_LAST) begin
            op  = OP_MAC;
            imm = COEF_W'(ramp_i * COEF_GAIN);
        end else begin
            unique case (s_i)
                S_STORE:  begin op = OP_STM;  addr = A_CUR;  end
                S_COMB:   begin op = OP_ADDM; addr = A_PREV; end
                S_EMIT:   begin op = OP_OUT;                 end
                S_RELOAD: begin op = OP_LDM;  addr = A_CUR;  end
                S_KEEP:   begin op = OP_STM;  addr = A_PREV; end
                S_CLEAR:  begin op = OP_SUBM; addr = A_PREV; end
                default:  begin op = OP_NOP;                 end
            endcase
        end
    end

endmodule

// File: rtl/dsm_acc_alu.sv
module dsm_acc_alu
    import dsm_decim_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int OUT_W     = 16,
    parameter int COEF_W    = 16,
    parameter int RAM_DEPTH = 4,
    parameter int RAM_AW    = 2,
    parameter int OUT_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  op_e               op,
    input  logic [RAM_AW-1:0] addr,
    input  logic [COEF_W-1:0] imm,
    output logic [OUT_W-1:0]  out_q,
    output logic              valid_q
);

    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] ram_q [RAM_DEPTH];
    logic signed [ACC_W-1:0] mem_rd;
    logic signed [ACC_W-1:0] imm_x;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] shifted;
    logic [OUT_W-1:0]        sat_word;

    always_comb begin
        mem_rd  = ram_q[addr];
        imm_x   = {{(ACC_W - COEF_W){imm[COEF_W-1]}}, imm};
        term    = din ? imm_x : -imm_x;
        shifted = acc_q >>> OUT_SHIFT;
        if (shifted > SAT_HI) begin
            sat_word = SAT_HI[OUT_W-1:0];
        end else if (shifted < SAT_LO) begin
            sat_word = SAT_LO[OUT_W-1:0];
        end else begin
            sat_word = shifted[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
            for (int i = 0; i < RAM_DEPTH; i++) begin
                ram_q[i] <= '0;
            end
        end else begin
            valid_q <= 1'b0;
            unique case (op)
                OP_NOP:  ;
                OP_LDI:  acc_q <= imm_x;
                OP_LDM:  acc_q <= mem_rd;
                OP_ADDM: acc_q <= acc_q + mem_rd;
                OP_SUBM: acc_q <= acc_q - mem_rd;
                OP_MAC:  acc_q <= acc_q + term;
                OP_STM:  ram_q[addr] <= acc_q;
                OP_OUT: begin
                    out_q   <= sat_word;
                    valid_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R1: the output strobe never lasts longer than one cycle
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R7: output register only moves together with a strobe
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(out_q));

    // R4: positive overflow clamps to the top code
    a_r4_clip_hi: assert property (@(posedge clk) disable iff (rst)
        (valid_q && (shifted > SAT_HI)) |-> (out_q == SAT_HI[OUT_W-1:0]));

    // R4: negative overflow clamps to the bottom code
    a_r4_clip_lo: assert property (@(posedge clk) disable iff (rst)
        (valid_q && (shifted < SAT_LO)) |-> (out_q == SAT_LO[OUT_W-1:0]));

    // R4: in-range values pass the shifted accumulator unchanged
    a_r4_pass: assert property (@(posedge clk) disable iff (rst)
        (valid_q && (shifted <= SAT_HI) && (shifted >= SAT_LO))
            |-> (out_q == shifted[OUT_W-1:0]));

endmodule

// File: rtl/dsm_microdecim.sv
module dsm_microdecim
    import dsm_decim_pkg::*;
#(
    parameter int STEPS     = 256,
    parameter int ACC_W     = 32,
    parameter int OUT_W     = 16,
    parameter int COEF_W    = 16,
    parameter int COEF_GAIN = 4,
    parameter int RAM_DEPTH = 4,
    parameter int OUT_SHIFT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [OUT_W-1:0] pcm_out,
    output logic             pcm_valid
);

    localparam int SEQ_W  = $clog2(STEPS);
    localparam int RAM_AW = $clog2(RAM_DEPTH);

    logic [SEQ_W-1:0]  step;
    op_e               op;
    logic [RAM_AW-1:0] addr;
    logic [COEF_W-1:0] imm;

    dsm_step_seq #(
        .STEPS (STEPS),
        .SEQ_W (SEQ_W)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .step (step)
    );

    dsm_prog_rom #(
        .STEPS     (STEPS),
        .SEQ_W     (SEQ_W),
        .RAM_AW    (RAM_AW),
        .COEF_W    (COEF_W),
        .COEF_GAIN (COEF_GAIN)
    ) u_rom (
        .step (step),
        .op   (op),
        .addr (addr),
        .imm  (imm)
    );

    dsm_acc_alu #(
        .ACC_W     (ACC_W),
        .OUT_W     (OUT_W),
        .COEF_W    (COEF_W),
        .RAM_DEPTH (RAM_DEPTH),
        .RAM_AW    (RAM_AW),
        .OUT_SHIFT (OUT_SHIFT)
    ) u_alu (
        .clk     (clk),
        .rst     (rst),
        .din     (bit_in),
        .op      (op),
        .addr    (addr),
        .imm     (imm),
        .out_q   (pcm_out),
        .valid_q (pcm_valid)
    );

endmodule

// File: tb/dsm_microdecim_tb.sv
module dsm_microdecim_tb;

    logic        clk;
    logic        rst;
    logic        bit_in;
    logic [15:0] pcm_out;
    logic        pcm_valid;

    int     checks;
    int     failures;
    bit     done;
    longint prev_part;
    longint last_out;

    dsm_microdecim u_dut (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .pcm_out   (pcm_out),
        .pcm_valid (pcm_valid)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic longint coef(input int s);
        int m;
        m = (s < 250 - s) ? s : 250 - s;
        return longint'(4 * m);
    endfunction

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 reset pcm_out", longint'($signed(pcm_out)), 0);
        check("R6 reset pcm_valid", longint'(pcm_valid), 0);
        prev_part = 0;
        last_out  = 0;
        rst = 1'b0;
    endtask

    // Starts at a negedge; step s executes on the posedge after bit s is set
    task automatic run_frame(input logic [255:0] pat, input string name);
        longint part;
        longint e;
        int     strobes;
        int     misplaced;
        part = 0;
        strobes = 0;
        misplaced = 0;
        for (int s = 1; s <= 249; s++) begin
            part += pat[s] ? coef(s) : -coef(s);
        end
        e = sat16((part + prev_part) >>> 1);
        for (int s = 0; s < 256; s++) begin
            bit_in = pat[s];
            @(negedge clk);
            if (pcm_valid) strobes++;
            if (pcm_valid != (s == 252)) misplaced++;
            if (s == 100) begin
                // R7: previous word still held mid-frame
                check({"R7 hold ", name}, longint'($signed(pcm_out)), last_out);
            end
            if (s == 252) begin
                // R3,R4,R5,R8: frame result
                check({"R3,R4,R5,R8 word ", name}, longint'($signed(pcm_out)), e);
            end
        end
        check({"R1,R2 strobe count ", name}, longint'(strobes), 1);
        check({"R1,R2 strobe position ", name}, longint'(misplaced), 0);
        prev_part = part;
        last_out  = e;
    endtask

    function automatic logic [255:0] rand_pat();
        logic [255:0] p;
        for (int k = 0; k < 8; k++) begin
            p[k*32 +: 32] = $urandom();
        end
        return p;
    endfunction

    initial begin
        logic [255:0] p;
        checks    = 0;
        failures  = 0;
        done      = 1'b0;
        prev_part = 0;
        last_out  = 0;
        rst       = 1'b1;
        bit_in    = 1'b0;
        void'($urandom(32'd20240611));

        do_reset();
        // R4,R5: first all-ones frame in range, second saturates high
        run_frame({256{1'b1}}, "ones-a");
        run_frame({256{1'b1}}, "ones-b");
        // R4,R5: zeros cancel previous ones, then saturate low
        run_frame({256{1'b0}}, "zeros-a");
        run_frame({256{1'b0}}, "zeros-b");
        run_frame({128{2'b10}}, "alternate");
        // R3: same MAC bits, non-MAC steps flipped
        p = rand_pat();
        p[0] = 1'b0;
        for (int s = 250; s < 256; s++) p[s] = 1'b0;
        run_frame(p, "outside-low");
        for (int s = 250; s < 256; s++) p[s] = 1'b1;
        p[0] = 1'b1;
        run_frame(p, "outside-high");
        for (int f = 0; f < 6; f++) begin
            run_frame(rand_pat(), "random");
        end
        // R6: reset in mid-frame, history must be cleared
        for (int s = 0; s < 100; s++) begin
            bit_in = 1'b1;
            @(negedge clk);
        end
        do_reset();
        run_frame({256{1'b1}}, "after-reset");
        for (int f = 0; f < 3; f++) begin
            run_frame(rand_pat(), "random-2");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule